// File: doc/BRIEF.md
# PLL Bring-up Sequencer

This block powers up and calibrates a shared SerDes PLL without software taking part in each step. A one-cycle start pulse begins a fixed program. The block first loads the PLL control fields and puts power and calibration under override control. It then lifts the PLL out of its low-power state and waits a short settling delay before it turns on the reference-clock buffer.

After that it runs a chain of handshakes, and each one waits on a status input under a timeout. Calibration is raised, then dropped, and the block waits for its done flag to clear. The PLL is enabled and the block waits for lock. Resistor calibration is raised, then dropped, and the block waits for its done flag to clear. When the chain completes, the block sets the automatic power sequencer's configuration, releases the overrides, waits the settling delay again and enables the sequencer. At that point `done` goes high. If any wait runs out, `error` goes high instead, and every control output holds its value.

The status inputs are taken to be synchronous to `clk`. The settling delay and the timeout are parameters given in clock cycles (`DLY_CYC`, `TMO_CYC`).

Top module: `pll_bringup_seq`

## Requirements
- R1: While reset is applied, and directly after it, `done`, `error` and every control output are 0, with these exceptions: `iddq`=1, `sleep`=3, `fb_div_m`=1, `rst_swctl`=1 and `clk_swctl`=1.
- R2: `start` is accepted only when the block is idle, done or in error. A pulse on `start` while a sequence is running has no effect on the outputs or on the cycle count to `done`.
- R3: Before calibration is first enabled, the block has set `cal_ctrl`=0x136, `osc_ctrl`=0x2A, all three overrides to 1, `txref_sel`=2, `txref_en`=1, `fb_div_n`=25, `fb_div_m`=0, `iddq`=0 and `sleep`=0.
- R4: `refbuf_en` rises exactly `DLY_CYC`+1 cycles after `sleep` becomes 0.
- R5: `cal_en` stays high until `cal_done_i` is sampled high, then drops. `pll_en` rises only after `cal_done_i` has been sampled low again.
- R6: The block waits for `pll_lock_i` after `pll_en` rises, and it raises no resistor-calibration enable before lock is seen.
- R7: `rcal_clk_en` and `rcal_en` rise together after lock. `rcal_en` drops once `rcal_done_i` is seen high. `rcal_clk_en` drops only after `rcal_done_i` has been sampled low again.
- R8: Each of the five waits succeeds when its status reaches the awaited level within `TMO_CYC` cycles of the enable change that starts the wait. Otherwise `error` rises exactly `TMO_CYC` cycles after that change.
- R9: In the handoff, `rst_swctl` and `clk_swctl` go to 0 and `use_lockdet` and `sleep_iddq` go to 1. After that the overrides clear, and `seq_en` rises exactly `DLY_CYC`+1 cycles after the overrides clear.
- R10: `done` rises in the same cycle as `seq_en` is seen high, 2·`DLY_CYC` + (sum of the five wait latencies) + 16 cycles after the start edge. It stays high until the next start.
- R11: After a timeout, `error` and all control outputs hold their values. A new start clears `error`, restarts from the first step, and in that step clears `cal_en`, `pll_en`, `rcal_en`, `rcal_clk_en`, `refbuf_en` and `seq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse |
| cal_done_i | input | 1 | PLL calibration done status |
| pll_lock_i | input | 1 | PLL lock status |
| rcal_done_i | input | 1 | Resistor calibration done status |
| done | output | 1 | Sequence completed |
| error | output | 1 | A wait timed out |
| cal_ctrl | output | 24 | Calibration control field |
| osc_ctrl | output | 8 | Oscillator control field |
| pwr_ovrd | output | 1 | Power override |
| cal_ovrd | output | 1 | Calibration override |
| rcal_ovrd | output | 1 | Resistor calibration override |
| txref_sel | output | 2 | TX clock reference select |
| txref_en | output | 1 | TX clock reference enable |
| fb_div_n | output | 8 | Feedback divider N |
| fb_div_m | output | 2 | Divider M |
| iddq | output | 1 | PLL quiescent power-down |
| sleep | output | 2 | PLL sleep field |
| refbuf_en | output | 1 | Reference clock buffer enable |
| cal_en | output | 1 | Calibration enable |
| pll_en | output | 1 | PLL enable |
| rcal_clk_en | output | 1 | Resistor calibration clock enable |
| rcal_en | output | 1 | Resistor calibration enable |
| rst_swctl | output | 1 | Software reset control of the sequencer |
| clk_swctl | output | 1 | Software clock-enable control of the sequencer |
| use_lockdet | output | 1 | Sequencer uses lock detect |
| sleep_iddq | output | 1 | Sequencer sleep-IDDQ setting |
| seq_en | output | 1 | Automatic power sequencer enable |

## Verification
The sharpest corner is the timeout edge. For each wait, the bench sweeps the status latency across 1, `TMO_CYC`-1, `TMO_CYC`, `TMO_CYC`+1 and "never". An off-by-one in the timeout counter would turn a response at exactly `TMO_CYC` into an error, or let `TMO_CYC`+1 pass. The bench also predicts the exact cycle of `done` or `error` from the latencies, so a wait that exits one sample late, or a settling delay that is one cycle short, shows up as a count mismatch. A design that kept sequencing after a timeout, cleared `cal_en` or `pll_en` on error, or failed to clear them on restart would fail the frozen-output and restart checks. A design that restarted on a start pulse in mid-run would show a shortened cycle count.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_PROG,
    ST_OVRD,
    ST_TXREF,
    ST_DIV,
    ST_IDDQ,
    ST_SLEEP,
    ST_DLY1,
    ST_REFBUF,
    ST_CAL_ON,
    ST_CAL_HI,
    ST_CAL_OFF,
    ST_CAL_LO,
    ST_PLL_ON,
    ST_LOCK,
    ST_RC_ON,
    ST_RC_HI,
    ST_RC_OFF,
    ST_RC_LO,
    ST_RCLK_OFF,
    ST_HANDOFF,
    ST_RELEASE,
    ST_DLY2,
    ST_SEQ_EN,
    ST_DONE,
    ST_ERR
  } step_e;

  localparam int CAL_W  = 24;
  localparam int OSC_W  = 8;
  localparam int NDIV_W = 8;

  localparam logic [CAL_W-1:0]  CAL_CTRL_VAL  = 24'h000136;
  localparam logic [OSC_W-1:0]  OSC_CTRL_VAL  = 8'h2A;
  localparam logic [1:0]        TXREF_SEL_VAL = 2'd2;
  localparam logic [NDIV_W-1:0] NDIV_VAL      = 8'd25;

  localparam logic [1:0] SLEEP_RST = 2'd3;
  localparam logic [1:0] MDIV_RST  = 2'd1;

endpackage

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (dec && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/pbs_ctrl.sv
module pbs_ctrl
  import pbs_pkg::*;
#(
  parameter int DLY_CYC = 100,
  parameter int TMO_CYC = 25_000_000,
  parameter int TW      = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cal_done_i,
  input  logic          pll_lock_i,
  input  logic          rcal_done_i,
  input  logic          tmr_zero,
  output step_e         step,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          tmr_dec
);

  localparam logic [TW-1:0] DLY_LD = TW'(DLY_CYC - 1);
  localparam logic [TW-1:0] TMO_LD = TW'(TMO_CYC - 1);

  step_e nxt;

  // a status wait: advance on the awaited level, abort on an expired timer
  function automatic step_e wait_on(input logic ok, input logic zero_now,
                                    input step_e go, input step_e here);
    if (ok)            return go;
    else if (zero_now) return ST_ERR;
    else               return here;
  endfunction

  always_comb begin
    nxt      = step;
    tmr_load = 1'b0;
    tmr_val  = TMO_LD;
    tmr_dec  = 1'b0;
    case (step)
      ST_IDLE, ST_DONE, ST_ERR: if (start) nxt = ST_PROG;
      ST_PROG:     nxt = ST_OVRD;
      ST_OVRD:     nxt = ST_TXREF;
      ST_TXREF:    nxt = ST_DIV;
      ST_DIV:      nxt = ST_IDDQ;
      ST_IDDQ:     nxt = ST_SLEEP;
      ST_SLEEP:    begin nxt = ST_DLY1; tmr_load = 1'b1; tmr_val = DLY_LD; end
      ST_DLY1:     begin tmr_dec = 1'b1; if (tmr_zero) nxt = ST_REFBUF; end
      ST_REFBUF:   nxt = ST_CAL_ON;
      ST_CAL_ON:   begin nxt = ST_CAL_HI; tmr_load = 1'b1; end
      ST_CAL_HI:   begin tmr_dec = 1'b1; nxt = wait_on(cal_done_i, tmr_zero, ST_CAL_OFF, step); end
      ST_CAL_OFF:  begin nxt = ST_CAL_LO; tmr_load = 1'b1; end
      ST_CAL_LO:   begin tmr_dec = 1'b1; nxt = wait_on(!cal_done_i, tmr_zero, ST_PLL_ON, step); end
      ST_PLL_ON:   begin nxt = ST_LOCK; tmr_load = 1'b1; end
      ST_LOCK:     begin tmr_dec = 1'b1; nxt = wait_on(pll_lock_i, tmr_zero, ST_RC_ON, step); end
      ST_RC_ON:    begin nxt = ST_RC_HI; tmr_load = 1'b1; end
      ST_RC_HI:    begin tmr_dec = 1'b1; nxt = wait_on(rcal_done_i, tmr_zero, ST_RC_OFF, step); end
      ST_RC_OFF:   begin nxt = ST_RC_LO; tmr_load = 1'b1; end
      ST_RC_LO:    begin tmr_dec = 1'b1; nxt = wait_on(!rcal_done_i, tmr_zero, ST_RCLK_OFF, step); end
      ST_RCLK_OFF: nxt = ST_HANDOFF;
      ST_HANDOFF:  nxt = ST_RELEASE;
      ST_RELEASE:  begin nxt = ST_DLY2; tmr_load = 1'b1; tmr_val = DLY_LD; end
      ST_DLY2:     begin tmr_dec = 1'b1; if (tmr_zero) nxt = ST_SEQ_EN; end
      ST_SEQ_EN:   nxt = ST_DONE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step <= ST_IDLE;
    else        step <= nxt;
  end

endmodule

// File: rtl/pbs_fields.sv
module pbs_fields
  import pbs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  step_e             step,
  output logic [CAL_W-1:0]  cal_ctrl,
  output logic [OSC_W-1:0]  osc_ctrl,
  output logic              pwr_ovrd,
  output logic              cal_ovrd,
  output logic              rcal_ovrd,
  output logic [1:0]        txref_sel,
  output logic              txref_en,
  output logic [NDIV_W-1:0] fb_div_n,
  output logic [1:0]        fb_div_m,
  output logic              iddq,
  output logic [1:0]        sleep,
  output logic              refbuf_en,
  output logic              cal_en,
  output logic              pll_en,
  output logic              rcal_clk_en,
  output logic              rcal_en,
  output logic              rst_swctl,
  output logic              clk_swctl,
  output logic              use_lockdet,
  output logic              sleep_iddq,
  output logic              seq_en
);

  // each action step writes its fields on the edge that leaves it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_ctrl    <= '0;
      osc_ctrl    <= '0;
      pwr_ovrd    <= 1'b0;
      cal_ovrd    <= 1'b0;
      rcal_ovrd   <= 1'b0;
      txref_sel   <= '0;
      txref_en    <= 1'b0;
      fb_div_n    <= '0;
      fb_div_m    <= MDIV_RST;
      iddq        <= 1'b1;
      sleep       <= SLEEP_RST;
      refbuf_en   <= 1'b0;
      cal_en      <= 1'b0;
      pll_en      <= 1'b0;
      rcal_clk_en <= 1'b0;
      rcal_en     <= 1'b0;
      rst_swctl   <= 1'b1;
      clk_swctl   <= 1'b1;
      use_lockdet <= 1'b0;
      sleep_iddq  <= 1'b0;
      seq_en      <= 1'b0;
    end else begin
      case (step)
        ST_PROG: begin
          cal_ctrl    <= CAL_CTRL_VAL;
          osc_ctrl    <= OSC_CTRL_VAL;
          refbuf_en   <= 1'b0;
          cal_en      <= 1'b0;
          pll_en      <= 1'b0;
          rcal_clk_en <= 1'b0;
          rcal_en     <= 1'b0;
          seq_en      <= 1'b0;
        end
        ST_OVRD: begin
          pwr_ovrd  <= 1'b1;
          cal_ovrd  <= 1'b1;
          rcal_ovrd <= 1'b1;
        end
        ST_TXREF: begin
          txref_sel <= TXREF_SEL_VAL;
          txref_en  <= 1'b1;
        end
        ST_DIV: begin
          fb_div_n <= NDIV_VAL;
          fb_div_m <= '0;
        end
        ST_IDDQ:     iddq        <= 1'b0;
        ST_SLEEP:    sleep       <= '0;
        ST_REFBUF:   refbuf_en   <= 1'b1;
        ST_CAL_ON:   cal_en      <= 1'b1;
        ST_CAL_OFF:  cal_en      <= 1'b0;
        ST_PLL_ON:   pll_en      <= 1'b1;
        ST_RC_ON: begin
          rcal_clk_en <= 1'b1;
          rcal_en     <= 1'b1;
        end
        ST_RC_OFF:   rcal_en     <= 1'b0;
        ST_RCLK_OFF: rcal_clk_en <= 1'b0;
        ST_HANDOFF: begin
          rst_swctl   <= 1'b0;
          clk_swctl   <= 1'b0;
          use_lockdet <= 1'b1;
          sleep_iddq  <= 1'b1;
        end
        ST_RELEASE: begin
          pwr_ovrd  <= 1'b0;
          cal_ovrd  <= 1'b0;
          rcal_ovrd <= 1'b0;
        end
        ST_SEQ_EN:   seq_en      <= 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
  import pbs_pkg::*;
#(
  parameter int DLY_CYC = 100,
  parameter int TMO_CYC = 25_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        cal_done_i,
  input  logic        pll_lock_i,
  input  logic        rcal_done_i,
  output logic        done,
  output logic        error,
  output logic [23:0] cal_ctrl,
  output logic [7:0]  osc_ctrl,
  output logic        pwr_ovrd,
  output logic        cal_ovrd,
  output logic        rcal_ovrd,
  output logic [1:0]  txref_sel,
  output logic        txref_en,
  output logic [7:0]  fb_div_n,
  output logic [1:0]  fb_div_m,
  output logic        iddq,
  output logic [1:0]  sleep,
  output logic        refbuf_en,
  output logic        cal_en,
  output logic        pll_en,
  output logic        rcal_clk_en,
  output logic        rcal_en,
  output logic        rst_swctl,
  output logic        clk_swctl,
  output logic        use_lockdet,
  output logic        sleep_iddq,
  output logic        seq_en
);

  localparam int CNT_MAX = (DLY_CYC > TMO_CYC) ? DLY_CYC : TMO_CYC;
  localparam int TW      = $clog2(CNT_MAX + 1);

  step_e         step;
  logic          tmr_load;
  logic          tmr_dec;
  logic          tmr_zero;
  logic [TW-1:0] tmr_val;

  pbs_ctrl #(
    .DLY_CYC (DLY_CYC),
    .TMO_CYC (TMO_CYC),
    .TW      (TW)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .cal_done_i  (cal_done_i),
    .pll_lock_i  (pll_lock_i),
    .rcal_done_i (rcal_done_i),
    .tmr_zero    (tmr_zero),
    .step        (step),
    .tmr_load    (tmr_load),
    .tmr_val     (tmr_val),
    .tmr_dec     (tmr_dec)
  );

  pbs_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .dec      (tmr_dec),
    .zero     (tmr_zero)
  );

  pbs_fields u_fields (
    .clk         (clk),
    .rst_n       (rst_n),
    .step        (step),
    .cal_ctrl    (cal_ctrl),
    .osc_ctrl    (osc_ctrl),
    .pwr_ovrd    (pwr_ovrd),
    .cal_ovrd    (cal_ovrd),
    .rcal_ovrd   (rcal_ovrd),
    .txref_sel   (txref_sel),
    .txref_en    (txref_en),
    .fb_div_n    (fb_div_n),
    .fb_div_m    (fb_div_m),
    .iddq        (iddq),
    .sleep       (sleep),
    .refbuf_en   (refbuf_en),
    .cal_en      (cal_en),
    .pll_en      (pll_en),
    .rcal_clk_en (rcal_clk_en),
    .rcal_en     (rcal_en),
    .rst_swctl   (rst_swctl),
    .clk_swctl   (clk_swctl),
    .use_lockdet (use_lockdet),
    .sleep_iddq  (sleep_iddq),
    .seq_en      (seq_en)
  );

  assign done  = (step == ST_DONE);
  assign error = (step == ST_ERR);

endmodule

// File: rtl/pbs_checker.sv
module pbs_checker
  import pbs_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        cal_done_i,
  input logic        pll_lock_i,
  input logic        rcal_done_i,
  input logic        done,
  input logic        error,
  input logic [23:0] cal_ctrl,
  input logic [7:0]  osc_ctrl,
  input logic        pwr_ovrd,
  input logic        cal_ovrd,
  input logic        rcal_ovrd,
  input logic [7:0]  fb_div_n,
  input logic        iddq,
  input logic [1:0]  sleep,
  input logic        refbuf_en,
  input logic        cal_en,
  input logic        pll_en,
  input logic        rcal_clk_en,
  input logic        rcal_en,
  input logic        rst_swctl,
  input logic        clk_swctl,
  input logic        use_lockdet,
  input logic        sleep_iddq,
  input logic        seq_en
);

  assert_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cal_en) |-> cal_ctrl == CAL_CTRL_VAL && osc_ctrl == OSC_CTRL_VAL &&
                      pwr_ovrd && cal_ovrd && rcal_ovrd && fb_div_n == NDIV_VAL &&
                      !iddq && sleep == 2'd0 && refbuf_en);

  assert_refbuf_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(refbuf_en) |-> sleep == 2'd0 && !iddq);

  assert_pll_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_en) |-> !cal_en && !$past(cal_done_i, 2));

  assert_rcal_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rcal_en) |-> pll_en && rcal_clk_en && $past(pll_lock_i, 2));

  assert_rclk_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rcal_clk_en) && !$past(error, 2) |-> !rcal_en && !$past(rcal_done_i, 2));

  assert_handoff_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_en) |-> !pwr_ovrd && !cal_ovrd && !rcal_ovrd && use_lockdet &&
                      sleep_iddq && !rst_swctl && !clk_swctl);

  assert_done_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && seq_en);

  assert_err_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && $stable(cal_en) && $stable(pll_en) &&
                        $stable(rcal_en) && $stable(rcal_clk_en) && $stable(seq_en));

endmodule

bind pll_bringup_seq pbs_checker i_pbs_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .cal_done_i  (cal_done_i),
  .pll_lock_i  (pll_lock_i),
  .rcal_done_i (rcal_done_i),
  .done        (done),
  .error       (error),
  .cal_ctrl    (cal_ctrl),
  .osc_ctrl    (osc_ctrl),
  .pwr_ovrd    (pwr_ovrd),
  .cal_ovrd    (cal_ovrd),
  .rcal_ovrd   (rcal_ovrd),
  .fb_div_n    (fb_div_n),
  .iddq        (iddq),
  .sleep       (sleep),
  .refbuf_en   (refbuf_en),
  .cal_en      (cal_en),
  .pll_en      (pll_en),
  .rcal_clk_en (rcal_clk_en),
  .rcal_en     (rcal_en),
  .rst_swctl   (rst_swctl),
  .clk_swctl   (clk_swctl),
  .use_lockdet (use_lockdet),
  .sleep_iddq  (sleep_iddq),
  .seq_en      (seq_en)
);

// File: tb/test_pll_bringup_seq.sv
module test_pll_bringup_seq;

  localparam int CLK_PERIOD = 10;
  localparam int DLY        = 4;
  localparam int TMO        = 20;
  localparam int NEVER      = 1000;
  localparam int WD_LIMIT   = 150000;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        cal_done_i;
  logic        pll_lock_i;
  logic        rcal_done_i;
  logic        done;
  logic        error;
  logic [23:0] cal_ctrl;
  logic [7:0]  osc_ctrl;
  logic        pwr_ovrd, cal_ovrd, rcal_ovrd;
  logic [1:0]  txref_sel;
  logic        txref_en;
  logic [7:0]  fb_div_n;
  logic [1:0]  fb_div_m;
  logic        iddq;
  logic [1:0]  sleep;
  logic        refbuf_en, cal_en, pll_en, rcal_clk_en, rcal_en;
  logic        rst_swctl, clk_swctl, use_lockdet, sleep_iddq, seq_en;

  pll_bringup_seq #(.DLY_CYC(DLY), .TMO_CYC(TMO)) i_pll_bringup_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cal_done_i(cal_done_i), .pll_lock_i(pll_lock_i), .rcal_done_i(rcal_done_i),
    .done(done), .error(error), .cal_ctrl(cal_ctrl), .osc_ctrl(osc_ctrl),
    .pwr_ovrd(pwr_ovrd), .cal_ovrd(cal_ovrd), .rcal_ovrd(rcal_ovrd),
    .txref_sel(txref_sel), .txref_en(txref_en), .fb_div_n(fb_div_n),
    .fb_div_m(fb_div_m), .iddq(iddq), .sleep(sleep), .refbuf_en(refbuf_en),
    .cal_en(cal_en), .pll_en(pll_en), .rcal_clk_en(rcal_clk_en), .rcal_en(rcal_en),
    .rst_swctl(rst_swctl), .clk_swctl(clk_swctl), .use_lockdet(use_lockdet),
    .sleep_iddq(sleep_iddq), .seq_en(seq_en)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int  n_chk = 0;
  int  n_fail = 0;
  int  cyc = 0;
  bit  finished = 0;

  // PHY response model: latencies 0..4 = cal up, cal down, lock, rcal up, rcal down
  int  lat [5];
  bit  model_on = 0;
  int  cal_on_c, cal_off_c, lock_c, rc_on_c, rc_off_c;

  always @(negedge clk) begin
    if (!rst_n || !model_on) begin
      cal_done_i = 0; pll_lock_i = 0; rcal_done_i = 0;
      cal_on_c = 0; cal_off_c = 0; lock_c = 0; rc_on_c = 0; rc_off_c = 0;
    end else begin
      if (cal_en) begin
        cal_off_c = 0;
        if (!cal_done_i) begin cal_on_c++; if (cal_on_c == lat[0]) cal_done_i = 1; end
      end else begin
        cal_on_c = 0;
        if (cal_done_i) begin cal_off_c++; if (cal_off_c == lat[1]) cal_done_i = 0; end
      end
      if (pll_en) begin
        if (!pll_lock_i) begin lock_c++; if (lock_c == lat[2]) pll_lock_i = 1; end
      end else begin
        lock_c = 0; pll_lock_i = 0;
      end
      if (rcal_en) begin
        rc_off_c = 0;
        if (!rcal_done_i) begin rc_on_c++; if (rc_on_c == lat[3]) rcal_done_i = 1; end
      end else begin
        rc_on_c = 0;
        if (rcal_done_i) begin rc_off_c++; if (rc_off_c == lat[4]) rcal_done_i = 0; end
      end
    end
  end

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT && !finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog: actual=%0d expected<=%0d", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_reset(input string when);
    // R1 vector: done error iddq sleep m rst_sw clk_sw seq pll cal refbuf ovrd lockdet
    chk("R1", when,
        {19'd0, done, error, iddq, sleep, fb_div_m, rst_swctl, clk_swctl,
         seq_en, pll_en, cal_en, refbuf_en, pwr_ovrd, use_lockdet},
        {19'd0, 1'b0, 1'b0, 1'b1, 2'd3, 2'd1, 1'b1, 1'b1,
         1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    chk("R1", {when, " fields"}, {cal_ctrl, osc_ctrl}, 32'd0);
  endtask

  task automatic run_seq(input int l0, input int l1, input int l2, input int l3,
                         input int l4, input int poke);
    int s_fail = -1;
    int sum_all = 0;
    int sum_bef = 0;
    int exp_n;
    int n = 0;
    int t_sleep = -1, t_ref = -1, t_oc = -1, t_seq = -1;
    logic p_sleep0, p_ref, p_ovr, p_seq;
    logic [8:0] snap;
    lat[0] = l0; lat[1] = l1; lat[2] = l2; lat[3] = l3; lat[4] = l4;
    for (int i = 0; i < 5; i++) begin
      if (s_fail < 0 && lat[i] > TMO) s_fail = i;
      if (s_fail < 0) sum_bef += lat[i];
      sum_all += lat[i];
    end
    if (s_fail < 0) exp_n = 2*DLY + sum_all + 16;
    else            exp_n = 8 + DLY + TMO + sum_bef + s_fail;

    model_on = 0;
    @(negedge clk) start = 1;
    @(posedge clk);
    @(negedge clk) start = 0;
    chk("R11", "status cleared by start", {done, error}, 2'b00);
    p_sleep0 = (sleep == 2'd0); p_ref = refbuf_en; p_ovr = pwr_ovrd; p_seq = seq_en;
    while (!done && !error && n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 3) model_on = 1;
      start = (poke != 0 && n == poke);
      if (sleep == 2'd0 && !p_sleep0 && t_sleep < 0) t_sleep = n;
      if (refbuf_en && !p_ref && t_ref < 0) t_ref = n;
      if (!pwr_ovrd && p_ovr && t_oc < 0) t_oc = n;
      if (seq_en && !p_seq && t_seq < 0) t_seq = n;
      p_sleep0 = (sleep == 2'd0); p_ref = refbuf_en; p_ovr = pwr_ovrd; p_seq = seq_en;
    end
    start = 0;

    if (s_fail < 0) begin
      chk("R10", "done raised", {done, error}, 2'b10);
      chk("R10", "cycles to done", n, exp_n);
      chk("R10", "seq_en with done", seq_en, 1'b1);
      chk("R3", "cal/osc fields", {cal_ctrl, osc_ctrl}, {24'h000136, 8'h2A});
      chk("R3", "div/tx/power fields", {fb_div_n, fb_div_m, txref_sel, txref_en, iddq, sleep},
          {8'd25, 2'd0, 2'd2, 1'b1, 1'b0, 2'd0});
      chk("R7", "enables at end", {cal_en, pll_en, rcal_en, rcal_clk_en, refbuf_en},
          5'b01001);
      chk("R9", "handoff fields",
          {rst_swctl, clk_swctl, use_lockdet, sleep_iddq, pwr_ovrd, cal_ovrd, rcal_ovrd},
          7'b0011000);
      if (t_sleep >= 0) chk("R4", "sleep clear to refbuf", t_ref - t_sleep, DLY + 1);
      chk("R9", "override release to seq_en", t_seq - t_oc, DLY + 1);
      repeat (5) @(negedge clk);
      chk("R10", "done held", {done, error}, 2'b10);
    end else begin
      chk("R8", "timeout raises error", {done, error}, 2'b01);
      chk("R8", "cycles to error", n, exp_n);
      chk("R11", "frozen outputs at error",
          {cal_en, pll_en, rcal_en, rcal_clk_en, seq_en, pwr_ovrd, cal_ovrd, rcal_ovrd},
          {s_fail == 0, s_fail >= 2, s_fail == 3, s_fail >= 3, 1'b0, 3'b111});
      snap = {cal_en, pll_en, rcal_en, rcal_clk_en, seq_en, pwr_ovrd, cal_ovrd,
              rcal_ovrd, refbuf_en};
      repeat (10) @(negedge clk);
      chk("R11", "outputs still held",
          {error, cal_en, pll_en, rcal_en, rcal_clk_en, seq_en, pwr_ovrd, cal_ovrd,
           rcal_ovrd, refbuf_en}, {1'b1, snap});
    end
    repeat (TMO + 10) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; start = 0;
    lat[0] = 3; lat[1] = 3; lat[2] = 3; lat[3] = 3; lat[4] = 3;
    repeat (3) @(negedge clk);
    check_reset("in reset");
    rst_n = 1;
    @(negedge clk);
    check_reset("after release");

    // first run after reset also measures the R4 settling gap
    run_seq(3, 3, 3, 3, 3, 0);
    // R2: start pulse while busy must not restart the sequence
    run_seq(3, 3, 3, 3, 3, 14);
    run_seq(2, 5, 1, 7, 4, 30);

    // equal latencies from one cycle up to the timeout boundary (R8, R10)
    for (int k = 1; k <= TMO; k++) run_seq(k, k, k, k, k, 0);

    // per-wait boundary sweep: R5 (cal), R6 (lock), R7 (rcal), R8 (timeout)
    for (int s = 0; s < 5; s++) begin
      for (int j = 0; j < 7; j++) begin
        int k;
        int l [5];
        case (j)
          0: k = 1;
          1: k = 2;
          2: k = TMO - 1;
          3: k = TMO;
          4: k = TMO + 1;
          5: k = TMO + 2;
          default: k = NEVER;
        endcase
        for (int i = 0; i < 5; i++) l[i] = (i == s) ? k : 3;
        run_seq(l[0], l[1], l[2], l[3], l[4], 0);
      end
    end

    // R11: restart straight after an error finishes normally
    run_seq(NEVER, 3, 3, 3, 3, 0);
    run_seq(4, 4, 4, 4, 4, 0);

    // R1: reset after a completed run returns the reset values
    @(negedge clk) rst_n = 0;
    @(negedge clk);
    check_reset("reset after done");
    rst_n = 1;
    @(negedge clk);
    run_seq(1, 1, 1, 1, 1, 0);

    summary();
  end

endmodule